// File: doc/BRIEF.md
# Resettable Line-Delay Memory

This block is a byte-wide line store with 5120 locations. Its write side and read side each have their own clock, an active-low enable and an active-low pointer clear. Each side keeps an address that steps through the array and wraps at the end. There are no occupancy flags. The delay between a byte going in and the same byte coming out is set only by how far apart the two pointer clears are.

A full line of delay comes from clearing both pointers in the same cycle. A shorter delay of n cycles comes from clearing the read pointer n cycles after the write pointer.

A written byte is held in a staging register for one edge before it reaches the array. The read side fetches on the first edge of its cycle. Because of this split, a read that lands on a location on the same edge as a new write to it still returns the older contents. This is what lets a whole-line delay work without any pointer offset.

Top module: `lineDelayMem`

## Requirements
- R1: Each side acts only on a rising edge of its own clock at which its enable (`wrEnN` / `rdEnN`) is low. A byte presented while `wrEnN` is high is never stored.
- R2: When `wrClrN` is low at a rising `wrClk` edge, that cycle's write (if enabled) goes to location 0 and the next enabled write goes to location 1. If the cycle is not enabled, the next enabled write goes to location 0.
- R3: When `rdClrN` is low at a rising `rdClk` edge, that cycle's read (if enabled) fetches location 0 and the next enabled read fetches location 1. If the cycle is not enabled, the next enabled read fetches location 0.
- R4: Each enabled access advances its address by one. The address wraps from DEPTH-1 to 0 with no indication, and later writes silently replace older contents.
- R5: While a side's enable is high, its address holds. While `rdEnN` is high, `dataOut` also keeps its last value.
- R6: `dataOut` is a register. It takes the word at the current read address on the rising `rdClk` edge of an enabled read cycle.
- R7: A byte sampled at write edge k is stored in the array at write edge k+1. A read of that location at edge k+1 returns the previous contents.
- R8: With DEPTH = 5120 words of 8 bits, clearing both pointers in the same cycle with both sides enabled makes the byte written in cycle k appear on `dataOut` after the read edge of cycle k+DEPTH.
- R9: With both sides enabled continuously, clearing the read pointer n cycles after the write pointer (2 ≤ n ≤ DEPTH) makes `dataOut` after the read edge of cycle n+j equal the byte written in cycle j.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wrClk | input | 1 | Write-side clock |
| wrEnN | input | 1 | Write enable, active low |
| wrClrN | input | 1 | Write pointer clear to location 0, active low, synchronous to `wrClk` |
| dataIn | input | DATA_W (8) | Byte to be written |
| rdClk | input | 1 | Read-side clock |
| rdEnN | input | 1 | Read enable, active low |
| rdClrN | input | 1 | Read pointer clear to location 0, active low, synchronous to `rdClk` |
| dataOut | output | DATA_W (8) | Registered read data |

## Verification
The assertions check the pointer arithmetic on every cycle once each side has seen its first clear:
- the landing on location 0 or 1 after a clear;
- the single step and the wrap at DEPTH-1;
- the freeze of the address and of `dataOut` while an enable is high.

Only the bench's scenarios can show the data relations:
- the n-cycle and full-line delays;
- the old-data return when a read meets a pending write on the same edge;
- the skipped bytes while writing is paused.

The bench therefore sweeps every delay on a 12-word copy and selected delays, up to 5120, on the full-size one.

// File: rtl/lineDelayPkg.sv
package lineDelayPkg;
  // strobes from control to datapath
  typedef struct packed {
    logic stageLoad;  // capture dataIn and the write address into the staging stage
    logic commit;     // write the staged byte into the array
    logic fetch;      // load dataOut from the array
  } lineStrobes_t;
endpackage

// File: rtl/lineDelayPtr.sv
module lineDelayPtr #(
  parameter int DEPTH  = 5120,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              clrN,
  input  logic              enN,
  output logic [ADDR_W-1:0] accAddr
);
  logic [ADDR_W-1:0] ptrQ;
  logic [ADDR_W-1:0] stepAddr;

  // a clear makes this cycle's access use location 0
  assign accAddr = clrN ? ptrQ : '0;

  generate
    if ((1 << ADDR_W) == DEPTH) begin : g_pow2
      assign stepAddr = accAddr + ADDR_W'(1);
    end else begin : g_cmp
      assign stepAddr = (accAddr == ADDR_W'(DEPTH - 1)) ? '0 : accAddr + ADDR_W'(1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    ptrQ <= enN ? accAddr : stepAddr;
  end
endmodule

// File: rtl/lineDelayCtrl.sv
module lineDelayCtrl
  import lineDelayPkg::*;
#(
  parameter int DEPTH  = 5120,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              wrEnN,
  input  logic              wrClrN,
  input  logic              rdEnN,
  input  logic              rdClrN,
  output lineStrobes_t      strobes,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr
);
  logic commitQ;

  lineDelayPtr #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_wrPtr (
    .clk(wrClk), .clrN(wrClrN), .enN(wrEnN), .accAddr(wrAddr)
  );

  lineDelayPtr #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_rdPtr (
    .clk(rdClk), .clrN(rdClrN), .enN(rdEnN), .accAddr(rdAddr)
  );

  // a byte staged on one edge is written on the next
  always_ff @(posedge wrClk) begin
    commitQ <= !wrEnN;
  end

  assign strobes.stageLoad = !wrEnN;
  assign strobes.commit    = commitQ;
  assign strobes.fetch     = !rdEnN;
endmodule

// File: rtl/lineDelayDatapath.sv
module lineDelayDatapath
  import lineDelayPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 5120,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  lineStrobes_t      strobes,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut
);
  logic [DATA_W-1:0] store [DEPTH];
  logic [DATA_W-1:0] stageData;
  logic [ADDR_W-1:0] stageAddr;
  logic [DATA_W-1:0] outQ;

  always_ff @(posedge wrClk) begin
    if (strobes.commit) begin
      store[stageAddr] <= stageData;
    end
    if (strobes.stageLoad) begin
      stageAddr <= wrAddr;
      stageData <= dataIn;
    end
  end

  always_ff @(posedge rdClk) begin
    if (strobes.fetch) begin
      outQ <= store[rdAddr];
    end
  end

  assign dataOut = outQ;
endmodule

// File: rtl/lineDelayMem.sv
module lineDelayMem
  import lineDelayPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 5120
) (
  input  logic              wrClk,
  input  logic              wrEnN,
  input  logic              wrClrN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              rdClk,
  input  logic              rdEnN,
  input  logic              rdClrN,
  output logic [DATA_W-1:0] dataOut
);
  localparam int ADDR_W = $clog2(DEPTH);

  lineStrobes_t      strobes;
  logic [ADDR_W-1:0] wrAddr;
  logic [ADDR_W-1:0] rdAddr;

  lineDelayCtrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ctrl (
    .wrClk(wrClk), .rdClk(rdClk),
    .wrEnN(wrEnN), .wrClrN(wrClrN),
    .rdEnN(rdEnN), .rdClrN(rdClrN),
    .strobes(strobes), .wrAddr(wrAddr), .rdAddr(rdAddr)
  );

  lineDelayDatapath #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_dp (
    .wrClk(wrClk), .rdClk(rdClk), .strobes(strobes),
    .wrAddr(wrAddr), .rdAddr(rdAddr),
    .dataIn(dataIn), .dataOut(dataOut)
  );
endmodule

// File: rtl/lineDelayChk.sv
module lineDelayChk #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 5120,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input logic              wrClk,
  input logic              rdClk,
  input logic              wrEnN,
  input logic              wrClrN,
  input logic              rdEnN,
  input logic              rdClrN,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [DATA_W-1:0] dataOut
);
  // each side is checked only after its first clear
  logic wrArmed = 1'b0;
  logic rdArmed = 1'b0;

  always_ff @(posedge wrClk) if (!wrClrN) wrArmed <= 1'b1;
  always_ff @(posedge rdClk) if (!rdClrN) rdArmed <= 1'b1;

  assert_wr_clear_origin_R2: assert property (@(posedge wrClk) disable iff (!wrArmed)
    ($past(!wrClrN) && wrClrN) |-> (wrAddr == ($past(wrEnN) ? ADDR_W'(0) : ADDR_W'(1))));

  assert_rd_clear_origin_R3: assert property (@(posedge rdClk) disable iff (!rdArmed)
    ($past(!rdClrN) && rdClrN) |-> (rdAddr == ($past(rdEnN) ? ADDR_W'(0) : ADDR_W'(1))));

  assert_wr_step_wrap_R4: assert property (@(posedge wrClk) disable iff (!wrArmed)
    ($past(wrClrN) && $past(!wrEnN) && wrClrN) |->
      (wrAddr == (($past(wrAddr) == ADDR_W'(DEPTH - 1)) ? ADDR_W'(0) : $past(wrAddr) + ADDR_W'(1))));

  assert_rd_step_wrap_R4: assert property (@(posedge rdClk) disable iff (!rdArmed)
    ($past(rdClrN) && $past(!rdEnN) && rdClrN) |->
      (rdAddr == (($past(rdAddr) == ADDR_W'(DEPTH - 1)) ? ADDR_W'(0) : $past(rdAddr) + ADDR_W'(1))));

  assert_wr_addr_range_R4: assert property (@(posedge wrClk) disable iff (!wrArmed)
    wrClrN |-> (wrAddr < ADDR_W'(DEPTH)));

  assert_wr_hold_R5: assert property (@(posedge wrClk) disable iff (!wrArmed)
    ($past(wrClrN) && $past(wrEnN) && wrClrN) |-> (wrAddr == $past(wrAddr)));

  assert_rd_hold_R5: assert property (@(posedge rdClk) disable iff (!rdArmed)
    ($past(rdClrN) && $past(rdEnN) && rdClrN) |-> (rdAddr == $past(rdAddr)));

  assert_out_hold_R5: assert property (@(posedge rdClk) disable iff (!rdArmed)
    rdEnN |=> $stable(dataOut));
endmodule

bind lineDelayMem lineDelayChk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .wrClk(wrClk), .rdClk(rdClk),
  .wrEnN(wrEnN), .wrClrN(wrClrN),
  .rdEnN(rdEnN), .rdClrN(rdClrN),
  .wrAddr(wrAddr), .rdAddr(rdAddr),
  .dataOut(dataOut)
);

// File: tb/lineDelayMem_tb.sv
`timescale 1ns/1ps
module lineDelayMem_tb;
  localparam int SMALL = 12;

  logic       clk = 1'b0;
  logic       wrEnN = 1'b1, wrClrN = 1'b1, rdEnN = 1'b1, rdClrN = 1'b1;
  logic [7:0] dIn = 8'h00;
  logic [7:0] outBig, outSmall;
  int         nChecks = 0, nFails = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  lineDelayMem u_dut (
    .wrClk(clk), .wrEnN(wrEnN), .wrClrN(wrClrN), .dataIn(dIn),
    .rdClk(clk), .rdEnN(rdEnN), .rdClrN(rdClrN), .dataOut(outBig)
  );

  lineDelayMem #(.DEPTH(SMALL)) u_small (
    .wrClk(clk), .wrEnN(wrEnN), .wrClrN(wrClrN), .dataIn(dIn),
    .rdClk(clk), .rdEnN(rdEnN), .rdClrN(rdClrN), .dataOut(outSmall)
  );

  function automatic logic [7:0] pat(int seed, int t);
    return 8'(t * 29 + (t >>> 8) * 113 + seed * 71 + 5);
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s at %0t: actual %02h expected %02h", req, $time, act, exp);
    end
  endtask

  // write clear in cycle 0, read clear in cycle n, both sides always enabled
  task automatic runDelay(int n, int total, bit chkSmall, bit chkBig, string tag);
    for (int t = 0; t < total; t++) begin
      @(negedge clk);
      wrEnN  = 1'b0;
      rdEnN  = 1'b0;
      wrClrN = (t == 0) ? 1'b0 : 1'b1;
      rdClrN = (t == n) ? 1'b0 : 1'b1;
      dIn    = pat(n, t);
      @(posedge clk);
      #1;
      if (t >= n) begin
        if (chkSmall) check(tag, outSmall, pat(n, t - n));
        if (chkBig)   check(tag, outBig,   pat(n, t - n));
      end
    end
  endtask

  // delay 1 on the small copy, run directly after the n=12 run of 42 cycles
  task automatic runSameEdge();
    for (int t = 0; t < 30; t++) begin
      @(negedge clk);
      wrEnN  = 1'b0;
      rdEnN  = 1'b0;
      wrClrN = (t == 0) ? 1'b0 : 1'b1;
      rdClrN = (t == 1) ? 1'b0 : 1'b1;
      dIn    = pat(1, t);
      @(posedge clk);
      #1;
      if (t >= 1) begin
        int j;
        logic [7:0] exp;
        j = t - 1;
        if (j < SMALL) exp = pat(12, (36 + j <= 41) ? 36 + j : 24 + j);
        else           exp = pat(1, j - SMALL);
        check("R7 same-edge read returns old word", outSmall, exp);
      end
    end
  endtask

  // delay 6 with pauses on both sides, checked against an index model
  task automatic runPauses();
    int wIdx = 0;
    int rIdx = 0;
    logic [7:0] exp = 8'h00;
    for (int t = 0; t < 60; t++) begin
      bit wEn, rEn;
      @(negedge clk);
      wEn    = !(t >= 20 && t <= 22);
      rEn    = !(t >= 30 && t <= 33);
      wrEnN  = !wEn;
      rdEnN  = !rEn;
      wrClrN = (t == 0) ? 1'b0 : 1'b1;
      rdClrN = (t == 6) ? 1'b0 : 1'b1;
      if (wEn) begin
        dIn = pat(200, wIdx);
        wIdx++;
      end else begin
        dIn = 8'hEE;
      end
      @(posedge clk);
      #1;
      if (t >= 6) begin
        if (rEn) begin
          exp = pat(200, rIdx);
          rIdx++;
        end
        check("R1 R5 pause", outSmall, exp);
        check("R1 R5 pause", outBig, exp);
      end
    end
  endtask

  initial begin
    // both pointers cleared with enables high: addresses rest at 0
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      wrClrN = 1'b0; rdClrN = 1'b0; wrEnN = 1'b1; rdEnN = 1'b1;
    end
    @(negedge clk);
    wrClrN = 1'b1; rdClrN = 1'b1; wrEnN = 1'b0; dIn = 8'hA5;
    @(negedge clk);
    wrEnN = 1'b1; dIn = 8'h3C;
    @(negedge clk);
    rdClrN = 1'b0; rdEnN = 1'b0;
    @(posedge clk);
    #1;
    check("R2 R3 R6 clear origin", outSmall, 8'hA5);
    check("R2 R3 R6 clear origin", outBig, 8'hA5);
    @(negedge clk);
    rdClrN = 1'b1; rdEnN = 1'b1;
    @(posedge clk);
    #1;
    check("R5 output hold", outSmall, 8'hA5);
    check("R5 output hold", outBig, 8'hA5);

    // every delay of the small copy; n = 12 is its full line
    for (int n = 2; n <= SMALL; n++) begin
      runDelay(n, n + 30, 1'b1, 1'b1, (n == SMALL) ? "R4 R8 R9" : "R9");
    end
    runSameEdge();

    // full-size copy
    runDelay(13, 43, 1'b0, 1'b1, "R9");
    runDelay(100, 5400, 1'b0, 1'b1, "R4 R9 wrap");
    runDelay(5119, 5139, 1'b0, 1'b1, "R9");
    runDelay(5120, 5150, 1'b0, 1'b1, "R8 full line");

    runPauses();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule